// File: doc/BRIEF.md
# Dual-Mode SD Card Clock Divider

This block derives the SD card clock from the core clock. An 11-bit ratio register stores the wanted division ratio less two. The card clock therefore runs at the core frequency divided by (stored value + 2). The same stored value is read in one of two ways:

- **Identification mode:** the whole 11-bit value sets the ratio. This gives the slow clock that a card needs before it has been identified.
- **Data mode:** only the three lowest bits are used. This gives fast clocks; with a 250 MHz core, values 0 to 3 yield 125, 83.3, 62.5 and 50 MHz.

The command path moves the block between the modes with two single-cycle pulses. One pulse marks that identification is over, or that the card has been sent back to data operation. The other forces identification again. A slow-card bit written together with the ratio keeps the full 11-bit ratio in use in either mode.

Alongside the card clock the block produces two single-core-cycle strobes. They mark the first core cycle of each high phase and of each low phase. Neighbouring logic uses them as clock enables to launch and capture on the card clock while running entirely on the core clock.

A new ratio, or a new mode, never cuts a card clock period short. The ratio in use is reloaded only when a full period ends.

Top module: `sdclk_divgen`

## Requirements
- R1: In identification mode with the slow-card bit clear, the card clock period is (stored value + 2) core cycles. For example, value 5 gives 7 cycles and value 0 gives 2 cycles.
- R2: The largest stored value, 0x7FF, gives a period of 2049 core cycles. No stored value stops the card clock; it keeps toggling.
- R3: In data mode with the slow-card bit clear, only bits [2:0] of the stored value count. The period is (value[2:0] + 2) core cycles, so for example 0x1FB gives 5 and 0x7F8 gives 2.
- R4: A pulse on `enter_data` puts the block in data mode from the next cycle, and a pulse on `enter_ident` puts it in identification mode. If both arrive in the same cycle, identification wins. Without a pulse the mode holds. `in_data_mode` shows the mode: 1 means data mode.
- R5: When the slow-card bit is 1, the full 11-bit stored value sets the period even in data mode. For example, value 10 gives 12 cycles.
- R6: In each period of N core cycles the card clock is high for floor(N/2) cycles first, then low for the remaining cycles.
- R7: A new stored value or a new mode takes effect only at the end of the current period. The period in progress keeps its old length, and the following period uses the new ratio.
- R8: `rise_stb` is 1 exactly in the first core cycle of each high phase of `sd_clk`, and `fall_stb` is 1 exactly in the first core cycle of each low phase. There is exactly one of each per period.
- R9: While `rst_n` is low, `sd_clk`, `rise_stb`, `fall_stb` and `in_data_mode` are 0. The stored value resets to 0x7FF with the slow-card bit clear. The first core cycle after reset starts a high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Loads `cfg_div` and `cfg_slow` into the configuration register |
| cfg_div | input | 11 | Division ratio minus two |
| cfg_slow | input | 1 | Slow-card bit: 1 keeps the full ratio in both modes |
| enter_data | input | 1 | Single-cycle pulse from the command path: switch to data mode |
| enter_ident | input | 1 | Single-cycle pulse from the command path: switch to identification mode (has priority) |
| sd_clk | output | 1 | Generated card clock |
| rise_stb | output | 1 | High in the first core cycle of each high phase |
| fall_stb | output | 1 | High in the first core cycle of each low phase |
| in_data_mode | output | 1 | 1 in data mode, 0 in identification mode |

## Verification
The internal state is small: a phase counter, a latched ratio and a mode bit. Each has a visible signature at the ports.

- **Corrupted phase counter:** shows within one period as a high or low run of the wrong length, or as a strobe that does not match a level change of `sd_clk`.
- **Wrong latched ratio or wrong mode decode:** changes the rise-to-rise spacing from the very next period boundary.
- **Ratio reloaded at the wrong moment:** shows as a shortened period in the cycles right after a write.

The checks therefore measure every period edge to edge. They compare the length of each low run with the high run before it, and count the core cycles between `rise_stb` pulses around each configuration write and mode pulse.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

   typedef enum logic {
      MODE_IDENT = 1'b0,
      MODE_DATA  = 1'b1
   } sd_mode_e;

   // number of core cycles per card-clock period for a stored value
   function automatic int unsigned ratio_of(input int unsigned stored);
      return stored + 2;
   endfunction

endpackage

// File: rtl/sdclk_mode_ctl.sv
module sdclk_mode_ctl
   import sdclk_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     enter_data,
   input  logic     enter_ident,
   output sd_mode_e mode
);

   sd_mode_e mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_IDENT;
      end else if (enter_ident) begin
         mode_q <= MODE_IDENT;
      end else if (enter_data) begin
         mode_q <= MODE_DATA;
      end
   end

   assign mode = mode_q;

endmodule

// File: rtl/sdclk_ratio_sel.sv
module sdclk_ratio_sel
   import sdclk_pkg::*;
#(
   parameter int DIV_W     = 11,
   parameter int DATA_BITS = 3,
   parameter int RST_DIV   = 2047,
   localparam int RW       = DIV_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             cfg_slow,
   input  sd_mode_e         mode,
   output logic [RW-1:0]    ratio
);

   localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(RST_DIV);

   logic [DIV_W-1:0] div_q;
   logic             slow_q;
   logic [DIV_W-1:0] data_val;
   logic [DIV_W-1:0] eff_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= RST_VAL;
         slow_q <= 1'b0;
      end else if (cfg_we) begin
         div_q  <= cfg_div;
         slow_q <= cfg_slow;
      end
   end

   generate
      if (DATA_BITS >= DIV_W) begin : g_full_data
         assign data_val = div_q;
      end else begin : g_narrow_data
         assign data_val = {{(DIV_W-DATA_BITS){1'b0}}, div_q[DATA_BITS-1:0]};
      end
   endgenerate

   always_comb begin
      if (slow_q || (mode == MODE_IDENT)) begin
         eff_val = div_q;
      end else begin
         eff_val = data_val;
      end
      ratio = RW'(ratio_of(int'(eff_val)));
   end

endmodule

// File: rtl/sdclk_phase_gen.sv
module sdclk_phase_gen
   import sdclk_pkg::*;
#(
   parameter int RW        = 12,
   parameter int RST_RATIO = 2049
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [RW-1:0] ratio_in,
   output logic          sd_clk,
   output logic          rise_stb,
   output logic          fall_stb
);

   localparam logic [RW-1:0] RST_R    = RW'(RST_RATIO);
   localparam logic [RW-1:0] RST_LAST = RW'(RST_RATIO - 1);

   logic [RW-1:0] cnt_q;
   logic [RW-1:0] ratio_q;
   logic          clk_q;
   logic          rise_q;
   logic          fall_q;

   logic          wrap;
   logic [RW-1:0] nxt_cnt;
   logic [RW-1:0] nxt_ratio;
   logic          nxt_clk;

   always_comb begin
      wrap      = (cnt_q == (ratio_q - 1'b1));
      nxt_ratio = wrap ? ratio_in : ratio_q;
      nxt_cnt   = wrap ? '0 : (cnt_q + 1'b1);
      nxt_clk   = (nxt_cnt < (nxt_ratio >> 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= RST_LAST;
         ratio_q <= RST_R;
         clk_q   <= 1'b0;
         rise_q  <= 1'b0;
         fall_q  <= 1'b0;
      end else begin
         cnt_q   <= nxt_cnt;
         ratio_q <= nxt_ratio;
         clk_q   <= nxt_clk;
         rise_q  <= nxt_clk & ~clk_q;
         fall_q  <= ~nxt_clk & clk_q;
      end
   end

   assign sd_clk   = clk_q;
   assign rise_stb = rise_q;
   assign fall_stb = fall_q;

endmodule

// File: rtl/sdclk_divgen.sv
module sdclk_divgen
   import sdclk_pkg::*;
#(
   parameter int DIV_W     = 11,
   parameter int DATA_BITS = 3,
   parameter int RST_DIV   = 2047
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             cfg_slow,
   input  logic             enter_data,
   input  logic             enter_ident,
   output logic             sd_clk,
   output logic             rise_stb,
   output logic             fall_stb,
   output logic             in_data_mode
);

   localparam int RW        = DIV_W + 1;
   localparam int RST_RATIO = RST_DIV + 2;

   generate
      if (DIV_W < 2) begin : g_bad_width
         $error("sdclk_divgen: DIV_W must be at least 2");
      end
      if ((DATA_BITS < 1) || (DATA_BITS > DIV_W)) begin : g_bad_data_bits
         $error("sdclk_divgen: DATA_BITS must lie in 1..DIV_W");
      end
      if ((RST_DIV < 0) || (RST_DIV > ((1 << DIV_W) - 1))) begin : g_bad_rst
         $error("sdclk_divgen: RST_DIV does not fit DIV_W bits");
      end
   endgenerate

   sd_mode_e      mode;
   logic [RW-1:0] ratio;

   sdclk_mode_ctl u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .enter_data (enter_data),
      .enter_ident(enter_ident),
      .mode       (mode)
   );

   sdclk_ratio_sel #(
      .DIV_W    (DIV_W),
      .DATA_BITS(DATA_BITS),
      .RST_DIV  (RST_DIV)
   ) u_ratio (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_we  (cfg_we),
      .cfg_div (cfg_div),
      .cfg_slow(cfg_slow),
      .mode    (mode),
      .ratio   (ratio)
   );

   sdclk_phase_gen #(
      .RW       (RW),
      .RST_RATIO(RST_RATIO)
   ) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .ratio_in(ratio),
      .sd_clk  (sd_clk),
      .rise_stb(rise_stb),
      .fall_stb(fall_stb)
   );

   assign in_data_mode = (mode == MODE_DATA);

endmodule

// File: rtl/sdclk_divgen_chk.sv
module sdclk_divgen_chk #(
   parameter int DIV_W = 11
) (
   input logic clk,
   input logic rst_n,
   input logic enter_data,
   input logic enter_ident,
   input logic sd_clk,
   input logic rise_stb,
   input logic fall_stb,
   input logic in_data_mode
);

   localparam int CW      = DIV_W + 2;
   localparam int MAX_RUN = ((1 << DIV_W) + 2) / 2;

   logic          prev_clk_q;
   logic [CW-1:0] run_q;
   logic [CW-1:0] hi_len_q;
   logic          seen_fall_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_clk_q  <= 1'b0;
         run_q       <= '0;
         hi_len_q    <= '0;
         seen_fall_q <= 1'b0;
      end else begin
         prev_clk_q <= sd_clk;
         run_q      <= (sd_clk != prev_clk_q) ? CW'(1) : (run_q + 1'b1);
         if (!sd_clk && prev_clk_q) begin
            hi_len_q    <= run_q;
            seen_fall_q <= 1'b1;
         end
      end
   end

   assert_rise_marks_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |-> (sd_clk && !prev_clk_q));
   assert_rose_has_stb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_clk && !prev_clk_q) |-> rise_stb);
   assert_fall_marks_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |-> (!sd_clk && prev_clk_q));
   assert_fell_has_stb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sd_clk && prev_clk_q) |-> fall_stb);
   assert_stb_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rise_stb, fall_stb}));
   assert_ident_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      enter_ident |=> !in_data_mode);
   assert_enter_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_data && !enter_ident) |=> in_data_mode);
   assert_mode_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!enter_data && !enter_ident) |=> $stable(in_data_mode));
   assert_no_runt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_fall_q && sd_clk && !prev_clk_q) |->
         ((run_q == hi_len_q) || (run_q == (hi_len_q + 1'b1))));
   assert_never_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= CW'(MAX_RUN));

endmodule

bind sdclk_divgen sdclk_divgen_chk #(.DIV_W(DIV_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .enter_data  (enter_data),
   .enter_ident (enter_ident),
   .sd_clk      (sd_clk),
   .rise_stb    (rise_stb),
   .fall_stb    (fall_stb),
   .in_data_mode(in_data_mode)
);

// File: tb/sdclk_divgen_tb.sv
module sdclk_divgen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [10:0] cfg_div = '0;
   logic        cfg_slow = 1'b0;
   logic        enter_data = 1'b0;
   logic        enter_ident = 1'b0;
   logic        sd_clk;
   logic        rise_stb;
   logic        fall_stb;
   logic        in_data_mode;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   sdclk_divgen u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we),
      .cfg_div     (cfg_div),
      .cfg_slow    (cfg_slow),
      .enter_data  (enter_data),
      .enter_ident (enter_ident),
      .sd_clk      (sd_clk),
      .rise_stb    (rise_stb),
      .fall_stb    (fall_stb),
      .in_data_mode(in_data_mode)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_cfg(input int div, input bit slow);
      @(negedge clk);
      cfg_we   = 1'b1;
      cfg_div  = 11'(div);
      cfg_slow = slow;
      @(negedge clk);
      cfg_we   = 1'b0;
   endtask

   task automatic pulse_mode(input bit dat, input bit idn);
      @(negedge clk);
      enter_data  = dat;
      enter_ident = idn;
      @(negedge clk);
      enter_data  = 1'b0;
      enter_ident = 1'b0;
   endtask

   task automatic wait_rise();
      @(negedge clk);
      while (!rise_stb) @(negedge clk);
   endtask

   // skip the period that may still use the old ratio
   task automatic settle();
      wait_rise();
      wait_rise();
   endtask

   // measure one period starting at the current rise strobe
   task automatic measure(input string req, input int exp_n);
      int n = 0;
      int h = 0;
      int falls = 0;
      while (!rise_stb) @(negedge clk);
      do begin
         if (sd_clk) h++;
         if (fall_stb) falls++;
         n++;
         @(negedge clk);
      end while (!rise_stb);
      check(n == exp_n, req, n, exp_n);
      check(h == exp_n / 2, "R6 high phase", h, exp_n / 2);
      check(falls == 1, "R8 one fall strobe", falls, 1);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check(sd_clk == 1'b0, "R9 clock low in reset", sd_clk, 0);
      check(rise_stb == 1'b0 && fall_stb == 1'b0, "R9 strobes low in reset",
            {rise_stb, fall_stb}, 0);
      check(in_data_mode == 1'b0, "R9 ident after reset", in_data_mode, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(sd_clk == 1'b1 && rise_stb == 1'b1, "R9 first cycle high",
            {sd_clk, rise_stb}, 3);
      measure("R2 max value period", 2049);
   endtask

   task automatic t_ident();
      write_cfg(5, 1'b0);
      settle();
      measure("R1 ident value 5", 7);
      write_cfg(0, 1'b0);
      settle();
      measure("R1 ident value 0", 2);
   endtask

   task automatic t_boundary();
      int n;
      write_cfg(5, 1'b0);
      settle();
      @(negedge clk);
      while (!rise_stb) @(negedge clk);
      cfg_we  = 1'b1;
      cfg_div = 11'd0;
      @(negedge clk);
      cfg_we  = 1'b0;
      n = 1;
      while (!rise_stb) begin
         n++;
         @(negedge clk);
      end
      check(n == 7, "R7 period in progress keeps length", n, 7);
      measure("R7 next period uses new value", 2);
   endtask

   task automatic t_data();
      write_cfg(11'h1FB, 1'b0);
      pulse_mode(1'b1, 1'b0);
      check(in_data_mode == 1'b1, "R4 enter data", in_data_mode, 1);
      settle();
      measure("R3 data low bits of 0x1FB", 5);
      for (int k = 0; k < 4; k++) begin
         write_cfg(11'h7F8 | k, 1'b0);
         settle();
         measure("R3 data value low bits", k + 2);
      end
   endtask

   task automatic t_slow();
      write_cfg(10, 1'b1);
      settle();
      measure("R5 slow bit full ratio in data mode", 12);
      write_cfg(10, 1'b0);
      settle();
      measure("R3 slow cleared uses low bits", 4);
      check(in_data_mode == 1'b1, "R4 mode holds", in_data_mode, 1);
   endtask

   task automatic t_ident_ret();
      pulse_mode(1'b1, 1'b1);
      check(in_data_mode == 1'b0, "R4 ident priority", in_data_mode, 0);
      settle();
      measure("R4 ident restores full ratio", 12);
      pulse_mode(1'b1, 1'b0);
      check(in_data_mode == 1'b1, "R4 data again", in_data_mode, 1);
      settle();
      measure("R3 data again low bits", 4);
   endtask

   initial begin
      t_reset();
      t_ident();
      t_boundary();
      t_data();
      t_slow();
      t_ident_ret();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule